// File: doc/BRIEF.md
# Virtual Plane Tag Shim for a Multi-Root Link

This block sits in the data link layer of a link that can carry traffic for several independent virtual hierarchies. On the transmit side it receives a framed TLP on a 32-bit beat stream. The first beat carries the link sequence number, and a function identifier travels alongside that first beat. The block looks the function up in a programmable mapping table and places one extra tag beat, holding the plane index, directly behind the sequence beat. The TLP header and payload follow unchanged. On the receive side it removes that tag beat. It passes the sequence beat and the untouched TLP upward and presents the plane index on a separate output for every beat of the packet.

Tagging is controlled per link by a multi-root enable input, sampled at the first beat of each packet. When tagging is off, both directions are a combinational pass-through and the reported plane is zero. The sequence word is never altered, so sequencing and acknowledgement stay per link. A replayed TLP from the same function gets the same tag as long as the table is not reprogrammed. A received packet that names a plane the device does not implement is discarded whole, and an error strobe is raised.

Top module: `vp_tag_shim`

## Requirements
- R1: With tagging enabled at the first beat, the transmit output shows that sequence beat unchanged in the same cycle. In the next cycle it shows a tag beat with sop=0 and eop=0, while tx_in_ready is low for exactly that one cycle. The tag word carries the plane index in bits [7:0] and zero in bits [31:8].
- R2: The transmitted plane is the mapping-table entry for tx_in_func, read at the first beat. All entries reset to plane 0. A write on the table port takes effect for packets that start after the write cycle.
- R3: Sending the same function twice, with no table write in between, gives identical tag words. The sequence beat and every following beat pass through bit-exact in both directions.
- R4: With tagging disabled at the first beat, both directions forward every beat in the same cycle with no stall. rx_out_plane is 0 and no tag beat is added or removed.
- R5: With tagging enabled on receive, the sequence beat is held and no output appears in its cycle. In the tag beat's cycle, the held sequence beat is emitted with sop=1 together with the plane index. Later beats leave in the cycle they arrive, with rx_out_plane equal to the received plane.
- R6: Bits [31:8] of a received tag word are ignored: any value there leaves the output data and the plane index unchanged.
- R7: A received tag whose plane index is at or above NUM_PLANES drops the whole packet, including the held sequence beat. rx_plane_err pulses high for one cycle, in the tag beat's cycle, and no output beat is produced for that packet.
- R8: A change of the enable input after the first beat of a packet has no effect on that packet in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mr_en | input | 1 | Multi-root tagging enable, sampled at each first beat |
| tbl_wr_en | input | 1 | Mapping-table write strobe |
| tbl_wr_func | input | FUNC_W | Function entry to write |
| tbl_wr_plane | input | 8 | Plane index to store |
| tx_in_valid | input | 1 | Transmit input beat valid |
| tx_in_ready | output | 1 | Transmit input accepted; low during tag insertion |
| tx_in_sop | input | 1 | First beat (sequence word) of a transmit packet |
| tx_in_eop | input | 1 | Last beat of a transmit packet |
| tx_in_func | input | FUNC_W | Originating function, valid with the first beat |
| tx_in_data | input | 32 | Transmit input beat |
| tx_out_valid | output | 1 | Transmit output beat valid |
| tx_out_sop | output | 1 | First beat of an outgoing packet |
| tx_out_eop | output | 1 | Last beat of an outgoing packet |
| tx_out_data | output | 32 | Transmit output beat |
| rx_in_valid | input | 1 | Receive input beat valid |
| rx_in_sop | input | 1 | First beat (sequence word) of a received packet |
| rx_in_eop | input | 1 | Last beat of a received packet |
| rx_in_data | input | 32 | Receive input beat |
| rx_out_valid | output | 1 | Receive output beat valid |
| rx_out_sop | output | 1 | First beat of a delivered packet |
| rx_out_eop | output | 1 | Last beat of a delivered packet |
| rx_out_data | output | 32 | Receive output beat |
| rx_out_plane | output | 8 | Plane index of the delivered packet |
| rx_plane_err | output | 1 | One-cycle strobe: packet dropped for an unimplemented plane |

## Verification
Transmit packets of one to three body beats are sent from several functions, with tagging on and off. This tells an inserted tag beat and its one-cycle stall apart from pure pass-through, and shows whether the tag really follows the table entry rather than the function number. Receive packets cover in-range planes up to the largest implemented one, the first plane beyond it and a far out-of-range value, always with nonzero reserved tag bits. These separate a correct strip from a drop and show that the reserved bits are ignored. Further packets toggle the enable in the middle of a packet, replay the same function, and reprogram an entry, which separates first-beat sampling and table timing from a design that reacts to the enable level at every beat.

// File: rtl/vp_tag_pkg.sv
package vp_tag_pkg;
   localparam int unsigned VP_DATA_W  = 32;
   localparam int unsigned VP_PLANE_W = 8;
   localparam int unsigned VP_MAX_PLANES = 1 << VP_PLANE_W;

   typedef logic [VP_DATA_W-1:0]  vp_beat_t;
   typedef logic [VP_PLANE_W-1:0] vp_plane_t;

   // Tag word: plane index in the low bits, reserved bits sent as zero.
   function automatic vp_beat_t vp_tag_word(input vp_plane_t plane);
      return {{(VP_DATA_W-VP_PLANE_W){1'b0}}, plane};
   endfunction
endpackage

// File: rtl/vp_map_table.sv
module vp_map_table
   import vp_tag_pkg::*;
#(
   parameter int unsigned NUM_FUNCS = 8,
   parameter int unsigned FUNC_W    = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FUNC_W-1:0] wr_func,
   input  vp_plane_t         wr_plane,
   input  logic [FUNC_W-1:0] rd_func,
   output vp_plane_t         rd_plane
);
   vp_plane_t ent_q [NUM_FUNCS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_FUNCS; i++) ent_q[i] <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < NUM_FUNCS; i++)
            if (wr_func == FUNC_W'(i)) ent_q[i] <= wr_plane;
      end
   end

   always_comb begin
      rd_plane = '0;
      for (int i = 0; i < NUM_FUNCS; i++)
         if (rd_func == FUNC_W'(i)) rd_plane = ent_q[i];
   end
endmodule

// File: rtl/vp_tx_insert.sv
module vp_tx_insert
   import vp_tag_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mr_en,
   input  vp_plane_t map_plane,
   input  logic      in_valid,
   output logic      in_ready,
   input  logic      in_sop,
   input  logic      in_eop,
   input  vp_beat_t  in_data,
   output logic      out_valid,
   output logic      out_sop,
   output logic      out_eop,
   output vp_beat_t  out_data
);
   logic      inj_q;
   vp_plane_t tag_q;
   logic      take_sop;

   assign in_ready = ~inj_q;
   assign take_sop = in_valid & in_ready & in_sop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_q <= 1'b0;
         tag_q <= '0;
      end else begin
         inj_q <= take_sop & mr_en;
         if (take_sop & mr_en) tag_q <= map_plane;
      end
   end

   always_comb begin
      if (inj_q) begin
         out_valid = 1'b1;
         out_sop   = 1'b0;
         out_eop   = 1'b0;
         out_data  = vp_tag_word(tag_q);
      end else begin
         out_valid = in_valid;
         out_sop   = in_valid & in_sop;
         out_eop   = in_valid & in_eop;
         out_data  = in_data;
      end
   end
endmodule

// File: rtl/vp_rx_strip.sv
module vp_rx_strip
   import vp_tag_pkg::*;
#(
   parameter int unsigned NUM_PLANES = 16
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mr_en,
   input  logic      in_valid,
   input  logic      in_sop,
   input  logic      in_eop,
   input  vp_beat_t  in_data,
   output logic      out_valid,
   output logic      out_sop,
   output logic      out_eop,
   output vp_beat_t  out_data,
   output vp_plane_t out_plane,
   output logic      plane_err
);
   logic      mr_q, hold_q, drop_q;
   vp_beat_t  seq_q;
   vp_plane_t plane_q;
   vp_plane_t tag_plane;
   logic      plane_ok;
   logic      sop_beat, tag_beat, body_beat;

   assign tag_plane = in_data[VP_PLANE_W-1:0];
   assign sop_beat  = in_valid & in_sop;
   assign tag_beat  = in_valid & ~in_sop & hold_q;
   assign body_beat = in_valid & ~in_sop & ~hold_q;

   generate
      if (NUM_PLANES >= VP_MAX_PLANES) begin : g_all_planes
         assign plane_ok = 1'b1;
      end else begin : g_range_check
         assign plane_ok = (tag_plane < VP_PLANE_W'(NUM_PLANES));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mr_q    <= 1'b0;
         hold_q  <= 1'b0;
         drop_q  <= 1'b0;
         seq_q   <= '0;
         plane_q <= '0;
      end else if (sop_beat) begin
         mr_q   <= mr_en;
         hold_q <= mr_en;
         drop_q <= 1'b0;
         seq_q  <= in_data;
      end else if (tag_beat) begin
         hold_q <= 1'b0;
         drop_q <= ~plane_ok;
         if (plane_ok) plane_q <= tag_plane;
      end
   end

   always_comb begin
      out_valid = 1'b0;
      out_sop   = 1'b0;
      out_eop   = 1'b0;
      out_data  = in_data;
      out_plane = '0;
      plane_err = 1'b0;
      if (sop_beat) begin
         if (!mr_en) begin
            out_valid = 1'b1;
            out_sop   = 1'b1;
            out_eop   = in_eop;
         end
      end else if (tag_beat) begin
         if (plane_ok) begin
            out_valid = 1'b1;
            out_sop   = 1'b1;
            out_data  = seq_q;
            out_plane = tag_plane;
         end else begin
            plane_err = 1'b1;
         end
      end else if (body_beat) begin
         out_valid = ~(mr_q & drop_q);
         out_eop   = in_eop & ~(mr_q & drop_q);
         out_plane = mr_q ? plane_q : '0;
      end
   end
endmodule

// File: rtl/vp_tag_shim.sv
module vp_tag_shim
   import vp_tag_pkg::*;
#(
   parameter int unsigned NUM_PLANES = 16,
   parameter int unsigned NUM_FUNCS  = 8,
   parameter int unsigned FUNC_W     = $clog2(NUM_FUNCS)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mr_en,
   input  logic              tbl_wr_en,
   input  logic [FUNC_W-1:0] tbl_wr_func,
   input  logic [7:0]        tbl_wr_plane,
   input  logic              tx_in_valid,
   output logic              tx_in_ready,
   input  logic              tx_in_sop,
   input  logic              tx_in_eop,
   input  logic [FUNC_W-1:0] tx_in_func,
   input  logic [31:0]       tx_in_data,
   output logic              tx_out_valid,
   output logic              tx_out_sop,
   output logic              tx_out_eop,
   output logic [31:0]       tx_out_data,
   input  logic              rx_in_valid,
   input  logic              rx_in_sop,
   input  logic              rx_in_eop,
   input  logic [31:0]       rx_in_data,
   output logic              rx_out_valid,
   output logic              rx_out_sop,
   output logic              rx_out_eop,
   output logic [31:0]       rx_out_data,
   output logic [7:0]        rx_out_plane,
   output logic              rx_plane_err
);
   generate
      if (NUM_PLANES < 1 || NUM_PLANES > VP_MAX_PLANES) begin : g_bad_planes
         $error("vp_tag_shim: NUM_PLANES must lie in 1..%0d", VP_MAX_PLANES);
      end
      if (NUM_FUNCS < 2 || NUM_FUNCS > (1 << FUNC_W)) begin : g_bad_funcs
         $error("vp_tag_shim: NUM_FUNCS must be at least 2 and fit FUNC_W");
      end
      if (VP_DATA_W != 32 || VP_PLANE_W != 8) begin : g_bad_widths
         $error("vp_tag_shim: port widths assume a 32-bit beat and 8-bit plane");
      end
   endgenerate

   vp_plane_t map_plane;

   vp_map_table #(
      .NUM_FUNCS (NUM_FUNCS),
      .FUNC_W    (FUNC_W)
   ) map_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr_en),
      .wr_func  (tbl_wr_func),
      .wr_plane (tbl_wr_plane),
      .rd_func  (tx_in_func),
      .rd_plane (map_plane)
   );

   vp_tx_insert tx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mr_en     (mr_en),
      .map_plane (map_plane),
      .in_valid  (tx_in_valid),
      .in_ready  (tx_in_ready),
      .in_sop    (tx_in_sop),
      .in_eop    (tx_in_eop),
      .in_data   (tx_in_data),
      .out_valid (tx_out_valid),
      .out_sop   (tx_out_sop),
      .out_eop   (tx_out_eop),
      .out_data  (tx_out_data)
   );

   vp_rx_strip #(
      .NUM_PLANES (NUM_PLANES)
   ) rx_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mr_en     (mr_en),
      .in_valid  (rx_in_valid),
      .in_sop    (rx_in_sop),
      .in_eop    (rx_in_eop),
      .in_data   (rx_in_data),
      .out_valid (rx_out_valid),
      .out_sop   (rx_out_sop),
      .out_eop   (rx_out_eop),
      .out_data  (rx_out_data),
      .out_plane (rx_out_plane),
      .plane_err (rx_plane_err)
   );
endmodule

// File: rtl/vp_tag_shim_chk.sv
module vp_tag_shim_chk #(
   parameter int unsigned NUM_PLANES = 16
)(
   input logic        clk,
   input logic        rst_n,
   input logic        mr_en,
   input logic        tx_in_valid,
   input logic        tx_in_ready,
   input logic        tx_in_sop,
   input logic [31:0] tx_in_data,
   input logic        tx_out_valid,
   input logic        tx_out_sop,
   input logic [31:0] tx_out_data,
   input logic        rx_in_valid,
   input logic        rx_in_sop,
   input logic [31:0] rx_in_data,
   input logic        rx_out_valid,
   input logic [31:0] rx_out_data,
   input logic [7:0]  rx_out_plane,
   input logic        rx_plane_err
);
   // R1
   tag_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && tx_in_ready && tx_in_sop && mr_en)
      |=> (!tx_in_ready && tx_out_valid && !tx_out_sop && tx_out_data[31:8] == 24'h0));

   // R1
   stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_in_ready |=> tx_in_ready);

   // R4
   tx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_in_valid && tx_in_ready && tx_in_sop && !mr_en)
      |-> (tx_out_valid && tx_out_data == tx_in_data));

   // R4
   rx_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && rx_in_sop && !mr_en)
      |-> (rx_out_valid && rx_out_plane == 8'h0 && rx_out_data == rx_in_data));

   // R5
   rx_hold_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_in_valid && rx_in_sop && mr_en) |-> !rx_out_valid);

   // R7
   drop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_plane_err |-> !rx_out_valid);

   // R7
   plane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_valid |-> ({1'b0, rx_out_plane} < 9'(NUM_PLANES)));
endmodule

bind vp_tag_shim vp_tag_shim_chk #(.NUM_PLANES(NUM_PLANES)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .mr_en        (mr_en),
   .tx_in_valid  (tx_in_valid),
   .tx_in_ready  (tx_in_ready),
   .tx_in_sop    (tx_in_sop),
   .tx_in_data   (tx_in_data),
   .tx_out_valid (tx_out_valid),
   .tx_out_sop   (tx_out_sop),
   .tx_out_data  (tx_out_data),
   .rx_in_valid  (rx_in_valid),
   .rx_in_sop    (rx_in_sop),
   .rx_in_data   (rx_in_data),
   .rx_out_valid (rx_out_valid),
   .rx_out_data  (rx_out_data),
   .rx_out_plane (rx_out_plane),
   .rx_plane_err (rx_plane_err)
);

// File: tb/vp_tag_shim_tb_top.sv
module vp_tag_shim_tb_top;
   localparam int unsigned NP = 12;
   localparam int unsigned NF = 8;
   localparam int unsigned FW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mr_en = 1'b0;
   logic          tbl_wr_en = 1'b0;
   logic [FW-1:0] tbl_wr_func = '0;
   logic [7:0]    tbl_wr_plane = '0;
   logic          tx_in_valid = 1'b0, tx_in_sop = 1'b0, tx_in_eop = 1'b0;
   logic [FW-1:0] tx_in_func = '0;
   logic [31:0]   tx_in_data = '0;
   logic          tx_in_ready, tx_out_valid, tx_out_sop, tx_out_eop;
   logic [31:0]   tx_out_data;
   logic          rx_in_valid = 1'b0, rx_in_sop = 1'b0, rx_in_eop = 1'b0;
   logic [31:0]   rx_in_data = '0;
   logic          rx_out_valid, rx_out_sop, rx_out_eop, rx_plane_err;
   logic [31:0]   rx_out_data;
   logic [7:0]    rx_out_plane;

   int   checks = 0;
   int   failures = 0;
   bit   done = 1'b0;
   logic [7:0] map_m [NF];

   always #5 clk = ~clk;

   vp_tag_shim #(.NUM_PLANES(NP), .NUM_FUNCS(NF), .FUNC_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mr_en(mr_en),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_func(tbl_wr_func), .tbl_wr_plane(tbl_wr_plane),
      .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_sop(tx_in_sop),
      .tx_in_eop(tx_in_eop), .tx_in_func(tx_in_func), .tx_in_data(tx_in_data),
      .tx_out_valid(tx_out_valid), .tx_out_sop(tx_out_sop), .tx_out_eop(tx_out_eop),
      .tx_out_data(tx_out_data),
      .rx_in_valid(rx_in_valid), .rx_in_sop(rx_in_sop), .rx_in_eop(rx_in_eop),
      .rx_in_data(rx_in_data),
      .rx_out_valid(rx_out_valid), .rx_out_sop(rx_out_sop), .rx_out_eop(rx_out_eop),
      .rx_out_data(rx_out_data), .rx_out_plane(rx_out_plane), .rx_plane_err(rx_plane_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_map(input int f, input logic [7:0] p);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_func = FW'(f); tbl_wr_plane = p;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      map_m[f] = p;
   endtask

   // Transmit one packet: sequence beat then len body beats.
   task automatic tx_pkt(input bit mr, input int f, input int len, input logic [31:0] base,
                         input bit flip, input string req, output logic [31:0] tag_seen);
      tag_seen = '0;
      @(negedge clk);
      mr_en = mr;
      tx_in_valid = 1'b1; tx_in_sop = 1'b1; tx_in_eop = 1'b0;
      tx_in_func = FW'(f); tx_in_data = base;
      #1;
      check(tx_out_valid && tx_out_sop && tx_in_ready && tx_out_data == base,
            req, "tx seq beat", {31'h0, tx_out_valid, tx_out_data}, {32'h1, base});
      if (mr) begin
         @(negedge clk);
         if (flip) mr_en = ~mr;
         tx_in_sop = 1'b0; tx_in_data = base + 1; tx_in_eop = (len == 1);
         #1;
         tag_seen = tx_out_data;
         check(!tx_in_ready && tx_out_valid && !tx_out_sop && !tx_out_eop &&
               tx_out_data == {24'h0, map_m[f]},
               req, "tx tag beat", {31'h0, tx_in_ready, tx_out_data}, {32'h0, 24'h0, map_m[f]});
      end
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         if (flip && !mr) mr_en = ~mr;
         tx_in_sop = 1'b0; tx_in_data = base + 32'(i); tx_in_eop = (i == len);
         #1;
         check(tx_in_ready && tx_out_valid && !tx_out_sop && tx_out_eop == (i == len) &&
               tx_out_data == base + 32'(i),
               req, "tx body beat", {31'h0, tx_out_eop, tx_out_data}, {31'h0, i == len, base + 32'(i)});
      end
      @(negedge clk);
      tx_in_valid = 1'b0; tx_in_eop = 1'b0; mr_en = mr;
   endtask

   // Receive one packet; on a tagged link the second beat is the tag word.
   task automatic rx_pkt(input bit mr, input int pl, input int len, input logic [31:0] base,
                         input bit flip, input string req);
      bit bad;
      logic [7:0] exp_pl;
      bad = mr && (pl >= NP);
      exp_pl = mr ? 8'(pl) : 8'h0;
      @(negedge clk);
      mr_en = mr;
      rx_in_valid = 1'b1; rx_in_sop = 1'b1; rx_in_eop = 1'b0; rx_in_data = base;
      #1;
      if (mr)
         check(!rx_out_valid, req, "rx seq held", {63'h0, rx_out_valid}, 64'h0);
      else
         check(rx_out_valid && rx_out_sop && rx_out_data == base && rx_out_plane == 8'h0,
               req, "rx bypass seq", {rx_out_plane, rx_out_data}, {8'h0, base});
      if (mr) begin
         @(negedge clk);
         if (flip) mr_en = ~mr;
         rx_in_sop = 1'b0; rx_in_data = {24'hA5C3E1, 8'(pl)};
         #1;
         if (bad)
            check(!rx_out_valid && rx_plane_err, "R7", "rx drop at tag",
                  {62'h0, rx_out_valid, rx_plane_err}, 64'h1);
         else
            check(rx_out_valid && rx_out_sop && !rx_plane_err && rx_out_data == base &&
                  rx_out_plane == 8'(pl),
                  req, "rx seq re-emit R6", {rx_out_plane, rx_out_data}, {8'(pl), base});
      end
      for (int i = 1; i <= len; i++) begin
         @(negedge clk);
         if (flip && !mr) mr_en = ~mr;
         rx_in_sop = 1'b0; rx_in_data = base + 32'(i); rx_in_eop = (i == len);
         #1;
         if (bad)
            check(!rx_out_valid && !rx_plane_err, "R7", "rx dropped body",
                  {62'h0, rx_out_valid, rx_plane_err}, 64'h0);
         else
            check(rx_out_valid && !rx_out_sop && rx_out_eop == (i == len) &&
                  rx_out_data == base + 32'(i) && rx_out_plane == exp_pl,
                  req, "rx body beat", {rx_out_plane, rx_out_data}, {exp_pl, base + 32'(i)});
      end
      @(negedge clk);
      rx_in_valid = 1'b0; rx_in_eop = 1'b0; mr_en = mr;
   endtask

   // Vector: {dir(1: rx), mr, flip, sel(8), len(4), base(32)}
   localparam int NV = 12;
   localparam logic [46:0] VEC [NV] = '{
      {1'b0, 1'b1, 1'b0, 8'd1,   4'd2, 32'h1000_0100},
      {1'b0, 1'b1, 1'b0, 8'd4,   4'd3, 32'h1000_0200},
      {1'b0, 1'b0, 1'b0, 8'd3,   4'd1, 32'h1000_0300},
      {1'b0, 1'b1, 1'b1, 8'd2,   4'd1, 32'h1000_0400},
      {1'b0, 1'b0, 1'b1, 8'd6,   4'd2, 32'h1000_0500},
      {1'b1, 1'b1, 1'b0, 8'd5,   4'd2, 32'h2000_0100},
      {1'b1, 1'b1, 1'b0, 8'd11,  4'd1, 32'h2000_0200},
      {1'b1, 1'b1, 1'b0, 8'd12,  4'd2, 32'h2000_0300},
      {1'b1, 1'b1, 1'b0, 8'd200, 4'd1, 32'h2000_0400},
      {1'b1, 1'b0, 1'b0, 8'd0,   4'd2, 32'h2000_0500},
      {1'b1, 1'b1, 1'b1, 8'd3,   4'd3, 32'h2000_0600},
      {1'b1, 1'b0, 1'b1, 8'd0,   4'd1, 32'h2000_0700}
   };

   initial begin
      logic [31:0] t0, t1;
      for (int f = 0; f < NF; f++) map_m[f] = 8'h0;
      #1;
      check(tx_out_valid == 1'b0 && rx_out_valid == 1'b0 && tx_in_ready == 1'b1 &&
            rx_plane_err == 1'b0, "R4", "reset state",
            {60'h0, tx_out_valid, rx_out_valid, tx_in_ready, rx_plane_err}, 64'h2);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: unprogrammed table gives plane 0
      tx_pkt(1'b1, 5, 1, 32'h0000_0055, 1'b0, "R2", t0);

      for (int f = 0; f < NF; f++) wr_map(f, 8'((f * 5 + 2) % NP));

      for (int v = 0; v < NV; v++) begin
         logic [46:0] e;
         e = VEC[v];
         if (e[46] == 1'b0)
            // R1 R3 R4 R8 on transmit
            tx_pkt(e[45], int'(e[43:36]), int'(e[35:32]), e[31:0], e[44],
                   e[44] ? "R8" : (e[45] ? "R1" : "R4"), t0);
         else
            // R5 R6 R7 R8 on receive
            rx_pkt(e[45], int'(e[43:36]), int'(e[35:32]), e[31:0], e[44],
                   e[44] ? "R8" : (e[45] ? "R5" : "R4"));
      end

      // R3: replay of the same function yields the same tag
      tx_pkt(1'b1, 4, 2, 32'h3000_0001, 1'b0, "R3", t0);
      tx_pkt(1'b1, 4, 2, 32'h3000_0001, 1'b0, "R3", t1);
      check(t0 == t1, "R3", "replayed tag", {32'h0, t1}, {32'h0, t0});

      // R2: reprogram entry, next packet follows new value
      wr_map(4, 8'd11);
      tx_pkt(1'b1, 4, 1, 32'h3000_0100, 1'b0, "R2", t1);
      check(t1 == 32'd11, "R2", "rewritten tag", {32'h0, t1}, 64'd11);

      // R7: strobe lasts one cycle, then a good packet flows again
      rx_pkt(1'b1, 13, 1, 32'h4000_0000, 1'b0, "R7");
      #1;
      check(!rx_plane_err, "R7", "err strobe cleared", {63'h0, rx_plane_err}, 64'h0);
      rx_pkt(1'b1, 0, 2, 32'h4000_0100, 1'b0, "R5");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog timeout actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule